// File: doc/BRIEF.md
# Fetch Address Sequencer with Wrong-Path Squash

This block owns the fetch-stage program counter of a five-stage in-order pipeline that has no delay slots. Every cycle it chooses the address to fetch next. It also decides whether the decode and execute instruction registers take their normal input or a no-op. Fetch always guesses the sequential address. Unconditional jumps are resolved while they sit in decode, so exactly one wrong-path fetch is squashed. Conditional branches are resolved in execute from the zero flag, so the two younger instructions are squashed.

The block holds the decode and execute instruction registers and the sequential address that travels with each of them. It computes both the absolute jump target and the relative branch target itself. The register-indirect target arrives already read from the register file, and a stall request arrives from the hazard unit. When several redirect causes meet, the instruction in execute is older and always wins.

The next-address choice is a named selector with five states. SRC_HOLD keeps the address during a stall. SRC_SEQ steps to the next word. SRC_BRANCH takes a branch resolved in execute. SRC_ABSOLUTE takes an absolute jump. SRC_INDIRECT takes a register jump. The selector is recomputed every cycle, so it can move from any state to any other. The order of priority fixes which state is chosen: SRC_BRANCH first, then SRC_HOLD, then SRC_ABSOLUTE, then SRC_INDIRECT, then SRC_SEQ.

Top module: `pc_redirect_ctl`

## Requirements
- R1: While reset is low and after its release, fetch_pc equals RESET_VEC (default 0x0000_0100), and dec_instr and exe_instr both hold the no-op word 0x0000_0000.
- R2: With no stall, no jump in decode and no taken branch in execute, next_pc is fetch_pc+4. On the next edge, dec_instr takes imem_rdata and exe_instr takes the old dec_instr.
- R3: An absolute jump in decode has opcode bits [31:26] equal to 0x02 or 0x03. With no stall and no taken branch, next_pc is {bits [31:28] of that jump's address+4, bits [25:0] of the jump, 2'b00}. dec_kill is high and only the one instruction fetched behind the jump becomes a no-op.
- R4: A register jump in decode has opcode 0x06 or 0x07. With no stall and no taken branch, next_pc equals reg_target and the one instruction fetched behind the jump is squashed.
- R5: A branch in execute is taken when the opcode is 0x04 and exe_zero is 1, or when the opcode is 0x05 and exe_zero is 0. Then next_pc is the branch's address+4 plus bits [15:0] sign-extended and shifted left by two, and both dec_instr and exe_instr become no-ops.
- R6: A branch in execute whose condition fails, either opcode 0x04 with exe_zero 0 or opcode 0x05 with exe_zero 1, leaves next_pc sequential and squashes nothing.
- R7: A taken branch in execute overrides a jump in decode and a stall. The branch target is used and both instruction registers are squashed.
- R8: With hazard_stall high and no taken branch, fetch_pc and dec_instr keep their values, and exe_instr receives a no-op.
- R9: A jump in decode does not redirect while hazard_stall is high. It is kept in decode and redirects in the first cycle the stall is low.
- R10: A negative branch offset (bit 15 set) produces a target below the branch's address+4.
- R11: dec_kill is high exactly when decode is loaded with a no-op, and exe_kill exactly when execute is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_rdata | input | 32 | Instruction fetched at fetch_pc |
| hazard_stall | input | 1 | Stall request from the hazard unit |
| exe_zero | input | 1 | Zero flag of the execute-stage operand |
| reg_target | input | XLEN | Register value for a register jump in decode |
| fetch_pc | output | XLEN | Current fetch address |
| next_pc | output | XLEN | Address loaded into fetch_pc at the next edge |
| dec_instr | output | 32 | Decode-stage instruction register |
| exe_instr | output | 32 | Execute-stage instruction register |
| dec_kill | output | 1 | Decode register loads a no-op this cycle |
| exe_kill | output | 1 | Execute register loads a no-op this cycle |

## Verification
The bench places a taken branch in execute while a jump sits in decode and a stall is raised. A design that ranked decode above execute would jump to the wrong place and let a dead instruction run. It holds a register jump in decode under a stall. A design that redirected anyway would use a target the hazard unit had not made valid, or would lose the jump altogether. It tries both polarities of each conditional branch and a negative offset. A wrong zero-flag sense or a missing sign extension then shows up as a wrong target or as squashed instructions that should have run. Stall cycles check that the fetch address and the decode register freeze while a bubble goes into execute. A design that let fetch advance would silently drop an instruction.

// File: rtl/pcctl_pkg.sv
package pcctl_pkg;

    localparam int ILEN  = 32;
    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_JUMP    = 6'h02;
    localparam logic [OPC_W-1:0] OPC_JLINK   = 6'h03;
    localparam logic [OPC_W-1:0] OPC_BRZERO  = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BRNZERO = 6'h05;
    localparam logic [OPC_W-1:0] OPC_JREG    = 6'h06;
    localparam logic [OPC_W-1:0] OPC_JREGLNK = 6'h07;

    localparam logic [ILEN-1:0] NOP_WORD = '0;

    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_SEQ,
        SRC_BRANCH,
        SRC_INDIRECT,
        SRC_ABSOLUTE
    } pc_src_e;

    typedef struct packed {
        logic brz;
        logic brnz;
        logic jabs;
        logic jind;
    } op_class_t;

endpackage

// File: rtl/pcctl_opclass.sv
module pcctl_opclass
    import pcctl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_class_t        cls
);

    always_comb begin
        cls = '0;
        unique case (opcode)
            OPC_JUMP, OPC_JLINK:     cls.jabs = 1'b1;
            OPC_JREG, OPC_JREGLNK:   cls.jind = 1'b1;
            OPC_BRZERO:              cls.brz  = 1'b1;
            OPC_BRNZERO:             cls.brnz = 1'b1;
            default:                 cls      = '0;
        endcase
    end

endmodule

// File: rtl/pcctl_arbiter.sv
module pcctl_arbiter
    import pcctl_pkg::*;
(
    input  op_class_t exe_cls,
    input  op_class_t dec_cls,
    input  logic      exe_zero,
    input  logic      stall,
    output pc_src_e   src,
    output logic      br_taken,
    output logic      dec_jump_go,
    output logic      dec_kill,
    output logic      exe_kill,
    output logic      dec_hold
);

    logic dec_jump;

    always_comb begin
        br_taken    = (exe_cls.brz && exe_zero) || (exe_cls.brnz && !exe_zero);
        dec_jump    = dec_cls.jabs || dec_cls.jind;
        dec_jump_go = dec_jump && !stall && !br_taken;

        // older execute-stage decision wins over everything in decode
        if (br_taken)          src = SRC_BRANCH;
        else if (stall)        src = SRC_HOLD;
        else if (dec_cls.jabs) src = SRC_ABSOLUTE;
        else if (dec_cls.jind) src = SRC_INDIRECT;
        else                   src = SRC_SEQ;
    end

    always_comb begin
        dec_kill = br_taken || (dec_jump && !stall);
        exe_kill = br_taken || stall;
        dec_hold = stall && !br_taken;
    end

endmodule

// File: rtl/pcctl_targets.sv
module pcctl_targets
    import pcctl_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int JF_W  = 26
) (
    input  pc_src_e            src,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-JF_W-3:0] dec_pc4_hi,
    input  logic [JF_W-1:0]    jump_field,
    input  logic [XLEN-1:0]    exe_pc4,
    input  logic [OFF_W-1:0]   br_offset,
    input  logic [XLEN-1:0]    reg_target,
    output logic [XLEN-1:0]    seq_pc,
    output logic [XLEN-1:0]    next_pc
);

    localparam int EXT_W = XLEN - OFF_W - 2;

    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] abs_target;

    always_comb begin
        seq_pc     = pc + XLEN'(4);
        br_target  = exe_pc4 + {{EXT_W{br_offset[OFF_W-1]}}, br_offset, 2'b00};
        abs_target = {dec_pc4_hi, jump_field, 2'b00};
    end

    always_comb begin
        unique case (src)
            SRC_HOLD:     next_pc = pc;
            SRC_SEQ:      next_pc = seq_pc;
            SRC_BRANCH:   next_pc = br_target;
            SRC_INDIRECT: next_pc = reg_target;
            SRC_ABSOLUTE: next_pc = abs_target;
            default:      next_pc = seq_pc;
        endcase
    end

endmodule

// File: rtl/pc_redirect_ctl.sv
module pc_redirect_ctl
    import pcctl_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              OFF_W     = 16,
    parameter int              JF_W      = 26,
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     imem_rdata,
    input  logic            hazard_stall,
    input  logic            exe_zero,
    input  logic [XLEN-1:0] reg_target,
    output logic [XLEN-1:0] fetch_pc,
    output logic [XLEN-1:0] next_pc,
    output logic [31:0]     dec_instr,
    output logic [31:0]     exe_instr,
    output logic            dec_kill,
    output logic            exe_kill
);

    localparam int OPC_LSB = ILEN - OPC_W;
    localparam int HI_W    = XLEN - JF_W - 2;

    logic [XLEN-1:0] pc_q, dec_pc4_q, exe_pc4_q, seq_pc;
    logic [ILEN-1:0] dec_q, exe_q;
    op_class_t       dec_cls, exe_cls;
    pc_src_e         pc_src;
    logic            br_taken, dec_jump_go, dec_hold;

    pcctl_opclass u_dec_cls (.opcode(dec_q[ILEN-1:OPC_LSB]), .cls(dec_cls));
    pcctl_opclass u_exe_cls (.opcode(exe_q[ILEN-1:OPC_LSB]), .cls(exe_cls));

    pcctl_arbiter u_arb (
        .exe_cls(exe_cls), .dec_cls(dec_cls), .exe_zero(exe_zero),
        .stall(hazard_stall), .src(pc_src), .br_taken(br_taken),
        .dec_jump_go(dec_jump_go), .dec_kill(dec_kill),
        .exe_kill(exe_kill), .dec_hold(dec_hold)
    );

    pcctl_targets #(.XLEN(XLEN), .OFF_W(OFF_W), .JF_W(JF_W)) u_tgt (
        .src(pc_src), .pc(pc_q),
        .dec_pc4_hi(dec_pc4_q[XLEN-1 -: HI_W]),
        .jump_field(dec_q[JF_W-1:0]),
        .exe_pc4(exe_pc4_q), .br_offset(exe_q[OFF_W-1:0]),
        .reg_target(reg_target), .seq_pc(seq_pc), .next_pc(next_pc)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= RESET_VEC;
            dec_q     <= NOP_WORD;
            exe_q     <= NOP_WORD;
            dec_pc4_q <= '0;
            exe_pc4_q <= '0;
        end else begin
            pc_q <= next_pc;
            if (dec_kill)       dec_q <= NOP_WORD;
            else if (!dec_hold) dec_q <= imem_rdata;
            if (!dec_hold)      dec_pc4_q <= seq_pc;
            exe_q     <= exe_kill ? NOP_WORD : dec_q;
            exe_pc4_q <= dec_pc4_q;
        end
    end

    always_comb begin
        fetch_pc  = pc_q;
        dec_instr = dec_q;
        exe_instr = exe_q;
    end

    // R5
    br_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (dec_instr == NOP_WORD && exe_instr == NOP_WORD));

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard_stall && !br_taken) |=>
            ($stable(fetch_pc) && $stable(dec_instr) && exe_instr == NOP_WORD));

    // R3
    jump_one_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_jump_go |=> (dec_instr == NOP_WORD && exe_instr == $past(dec_instr)));

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src == SRC_SEQ) |=>
            (fetch_pc == $past(fetch_pc) + XLEN'(4) && dec_instr == $past(imem_rdata)
             && exe_instr == $past(dec_instr)));

    // R11
    kill_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_kill && !exe_kill) |-> !hazard_stall);

endmodule

// File: tb/pc_redirect_ctl_bench.sv
`timescale 1ns/1ps
module pc_redirect_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_rdata = '0;
    logic        hazard_stall = 1'b0;
    logic        exe_zero = 1'b0;
    logic [31:0] reg_target = '0;
    logic [31:0] fetch_pc, next_pc, dec_instr, exe_instr;
    logic        dec_kill, exe_kill;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pc_redirect_ctl u_pc_redirect_ctl (
        .clk(clk), .rst_n(rst_n), .imem_rdata(imem_rdata),
        .hazard_stall(hazard_stall), .exe_zero(exe_zero),
        .reg_target(reg_target), .fetch_pc(fetch_pc), .next_pc(next_pc),
        .dec_instr(dec_instr), .exe_instr(exe_instr),
        .dec_kill(dec_kill), .exe_kill(exe_kill)
    );

    // reference state built from the requirements
    logic [31:0] m_pc, m_dec, m_exe, m_dec_pc4, m_exe_pc4;

    typedef struct packed {
        logic [31:0] pc;
        logic [31:0] dec;
        logic [31:0] exe;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, check combinational outputs, push expected registers
    task automatic step(logic [31:0] ins, logic z, logic st, logic [31:0] rt, string tag);
        logic [5:0] eop, dop;
        logic br, jmp, dk, ek;
        logic [31:0] nx;
        exp_t e;
        @(negedge clk);
        imem_rdata = ins; exe_zero = z; hazard_stall = st; reg_target = rt;
        #1;
        eop = m_exe[31:26];
        dop = m_dec[31:26];
        br  = (eop == 6'h04 && z) || (eop == 6'h05 && !z);
        jmp = (dop == 6'h02) || (dop == 6'h03) || (dop == 6'h06) || (dop == 6'h07);
        if (br)                                nx = m_exe_pc4 + {{14{m_exe[15]}}, m_exe[15:0], 2'b00};
        else if (st)                           nx = m_pc;
        else if (dop == 6'h02 || dop == 6'h03) nx = {m_dec_pc4[31:28], m_dec[25:0], 2'b00};
        else if (dop == 6'h06 || dop == 6'h07) nx = rt;
        else                                   nx = m_pc + 32'd4;
        dk = br || (!st && jmp);
        ek = br || st;
        check(tag, "next_pc", next_pc, nx);
        check(tag, "dec_kill (R11)", {31'd0, dec_kill}, {31'd0, dk});
        check(tag, "exe_kill (R11)", {31'd0, exe_kill}, {31'd0, ek});
        m_exe     = ek ? 32'd0 : m_dec;
        m_exe_pc4 = m_dec_pc4;
        if (dk)       m_dec = 32'd0;
        else if (!st) m_dec = ins;
        if (!st || br) m_dec_pc4 = (st && br) ? m_dec_pc4 : m_pc + 32'd4;
        m_pc = nx;
        e.pc = m_pc; e.dec = m_dec; e.exe = m_exe;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // monitor: compare registered outputs after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "fetch_pc", fetch_pc, e.pc);
                check(t, "dec_instr", dec_instr, e.dec);
                check(t, "exe_instr", exe_instr, e.exe);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    localparam logic [31:0] RT = 32'h0000_4000;

    initial begin
        m_pc = 32'h0000_0100; m_dec = '0; m_exe = '0; m_dec_pc4 = '0; m_exe_pc4 = '0;
        repeat (3) @(posedge clk);
        #2;
        check("R1", "fetch_pc in reset", fetch_pc, 32'h0000_0100);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        // R1 after release, before any stimulus edge is compared
        check("R1", "dec_instr after reset", dec_instr, 32'd0);
        check("R1", "exe_instr after reset", exe_instr, 32'd0);
        // first edge after release advanced sequentially from the reset vector
        m_pc = 32'h0000_0104; m_dec = 32'd0; m_dec_pc4 = 32'h0000_0104;
        check("R1", "fetch_pc after release", fetch_pc, 32'h0000_0104);

        // R2 sequential flow
        step(32'h2000_0001, 0, 0, RT, "R2");
        step(32'h2000_0002, 0, 0, RT, "R2");
        step(32'h2000_0003, 0, 0, RT, "R2");
        // R3 absolute jump
        step(32'h0800_0040, 0, 0, RT, "R3");
        step(32'h2000_0004, 0, 0, RT, "R3");
        step(32'h2000_0005, 0, 0, RT, "R3");
        // R4 register jump
        step(32'h1800_0000, 0, 0, RT, "R4");
        step(32'h2000_0006, 0, 0, RT, "R4");
        step(32'h2000_0007, 0, 0, RT, "R4");
        // R5 taken zero branch
        step(32'h1000_0010, 0, 0, RT, "R5");
        step(32'h2000_0008, 0, 0, RT, "R5");
        step(32'h2000_0009, 1, 0, RT, "R5");
        step(32'h2000_000a, 0, 0, RT, "R5");
        step(32'h2000_000b, 0, 0, RT, "R5");
        // R6 non-zero branch, condition fails
        step(32'h1400_0020, 1, 0, RT, "R6");
        step(32'h2000_000c, 1, 0, RT, "R6");
        step(32'h2000_000d, 1, 0, RT, "R6");
        step(32'h2000_000e, 0, 0, RT, "R6");
        // R10 non-zero branch taken with negative offset
        step(32'h1400_fff8, 1, 0, RT, "R10");
        step(32'h2000_000f, 1, 0, RT, "R10");
        step(32'h2000_0010, 0, 0, RT, "R10");
        step(32'h2000_0011, 0, 0, RT, "R10");
        // R8 stall without redirect
        step(32'h2000_0012, 0, 0, RT, "R8");
        step(32'h2000_0013, 0, 1, RT, "R8");
        step(32'h2000_0014, 0, 1, RT, "R8");
        step(32'h2000_0015, 0, 0, RT, "R8");
        // R9 register jump held under stall
        step(32'h1c00_0000, 0, 0, RT, "R9");
        step(32'h2000_0016, 0, 1, 32'h0000_dead, "R9");
        step(32'h2000_0017, 0, 1, 32'h0000_beef, "R9");
        step(32'h2000_0018, 0, 0, 32'h0000_8000, "R9");
        step(32'h2000_0019, 0, 0, RT, "R9");
        // R7 taken branch in execute beats jump in decode and stall
        step(32'h1000_0004, 0, 0, RT, "R7");
        step(32'h0c00_0100, 0, 0, RT, "R7");
        step(32'h2000_001a, 1, 1, RT, "R7");
        step(32'h2000_001b, 0, 0, RT, "R7");
        step(32'h2000_001c, 0, 0, RT, "R7");
        repeat (2) @(posedge clk);
        #3;
        finish_run();
    end

endmodule